// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Controller

This block is a register-mapped controller for a bank of general-purpose pins, 28 by default. Software reaches it through a simple word-addressed bus. The bus has a 3-bit word index, a write strobe, 32-bit write data and combinational 32-bit read data. Through this bus software can:

- choose per pin whether the block drives it;
- raise or lower output bits with separate write-one-to-set and write-one-to-clear words, so no read-modify-write is needed;
- read the synchronized level of every pin.

Each pin input passes through a two-flop synchronizer and one further delay flop. Comparing the synchronized value with the delayed copy gives one-cycle rise and fall pulses. Per-pin enables select which pulses latch into a sticky status word. Software clears that word by writing ones. The low status bits each drive a dedicated interrupt line, and the remaining bits share one combined line. A spare storage word keeps per-pin function-select bits for neighbouring pad logic.

Top module: `gpio_edge_unit`

## Requirements
- R1: After reset the direction, output latch, rise enable, fall enable, status and function-select words are all zero, so `pin_oe`, `pin_out`, `irq_solo` and `irq_upper` are all zero.
- R2: A read of word 0 returns the pin levels as seen two clock edges after they change, whatever each pin's direction.
- R3: Word 1 is the direction word and reads back as written; a 1 in bit n drives `pin_oe[n]` high, making pin n an output.
- R4: A write to word 2 sets every output latch bit written as 1 and leaves the others unchanged. `pin_out` shows the latch from the next edge.
- R5: A write to word 3 clears every output latch bit written as 1 and leaves the others unchanged.
- R6: Words 2 and 3 always read as zero.
- R7: With bit n of the rise enable (word 4) set, a 0-to-1 change on pin n sets status bit n on the third clock edge after the change.
- R8: With bit n of the fall enable (word 5) set, a 1-to-0 change on pin n sets status bit n. An edge whose enable is 0 leaves status unchanged, and with both enables set either edge is detected.
- R9: The status word (word 6) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: When a detected edge and a clear hit the same status bit on the same edge, the bit stays set.
- R11: `irq_solo[n]` equals status bit n for pins 0 to 10. `irq_upper` is the OR of status bits 11 to 27.
- R12: Word 7 stores function-select bits and reads back as written. In every word, bits above the pin count read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_word | input | 3 | Word index (byte offset divided by four) |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Output latch value |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq_solo | output | NUM_SOLO | Dedicated interrupt per low pin |
| irq_upper | output | 1 | Combined interrupt for the remaining pins |

## Verification
The bench builds the block with its defaults: 28 pins, with the first 11 on dedicated interrupt lines. This makes the four unused top bits of every word visible, so writing all-ones checks that they are ignored. Pins 3, 4 and 21 fall on both sides of the split between dedicated and combined interrupts. The bench times a clear write onto the same edge where a synchronized rise reaches the status word, to reach the edge-wins collision.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        SEL_LEVEL = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_SET   = 3'd2,
        SEL_CLR   = 3'd3,
        SEL_RISE  = 3'd4,
        SEL_FALL  = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_ALT   = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_in;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.stable;
    assign rise  = st_q.stable & ~st_q.prev;
    assign fall  = ~st_q.stable & st_q.prev;

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wr_bits,
    input  logic [WIDTH-1:0] rise,
    input  logic [WIDTH-1:0] fall,
    output logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] latch,
    output logic [WIDTH-1:0] rise_en,
    output logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] alt
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] rise_en;
        logic [WIDTH-1:0] fall_en;
        logic [WIDTH-1:0] status;
        logic [WIDTH-1:0] alt;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_DIR:  rg_d.dir     = wr_bits;
                SEL_SET:  rg_d.latch   = rg_q.latch | wr_bits;
                SEL_CLR:  rg_d.latch   = rg_q.latch & ~wr_bits;
                SEL_RISE: rg_d.rise_en = wr_bits;
                SEL_FALL: rg_d.fall_en = wr_bits;
                SEL_STAT: rg_d.status  = rg_q.status & ~wr_bits;
                SEL_ALT:  rg_d.alt     = wr_bits;
                default:  ;
            endcase
        end
        // a fresh edge overrides a same-cycle clear
        rg_d.status = rg_d.status | (rise & rg_q.rise_en) | (fall & rg_q.fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign dir     = rg_q.dir;
    assign latch   = rg_q.latch;
    assign rise_en = rg_q.rise_en;
    assign fall_en = rg_q.fall_en;
    assign status  = rg_q.status;
    assign alt     = rg_q.alt;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int WIDTH    = 28,
    parameter int NUM_SOLO = 11
) (
    input  logic [WIDTH-1:0]    status,
    output logic [NUM_SOLO-1:0] irq_solo,
    output logic                irq_upper
);

    for (genvar g = 0; g < NUM_SOLO; g++) begin : g_solo
        assign irq_solo[g] = status[g];
    end

    if (NUM_SOLO < WIDTH) begin : g_upper
        assign irq_upper = |status[WIDTH-1:NUM_SOLO];
    end else begin : g_no_upper
        assign irq_upper = 1'b0;
    end

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 28,
    parameter int NUM_SOLO = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_word,
    input  logic                bus_we,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_SOLO-1:0] irq_solo,
    output logic                irq_upper
);

    logic [NUM_PINS-1:0] wdata_pins;
    logic [NUM_PINS-1:0] level, rise, fall;
    logic [NUM_PINS-1:0] dir, latch, rise_en, fall_en, status, alt;
    logic [NUM_PINS-1:0] rd_pins;
    reg_sel_e            sel;

    assign sel        = reg_sel_e'(bus_word);
    assign wdata_pins = bus_wdata[NUM_PINS-1:0];

    if (NUM_PINS < BUS_W) begin : g_spare
        logic wdata_unused;
        assign wdata_unused = ^bus_wdata[BUS_W-1:NUM_PINS];
    end

    gpio_edge_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    gpio_edge_regs #(.WIDTH(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_sel  (sel),
        .wr_bits (wdata_pins),
        .rise    (rise),
        .fall    (fall),
        .dir     (dir),
        .latch   (latch),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .status  (status),
        .alt     (alt)
    );

    gpio_edge_irq #(.WIDTH(NUM_PINS), .NUM_SOLO(NUM_SOLO)) u_irq (
        .status    (status),
        .irq_solo  (irq_solo),
        .irq_upper (irq_upper)
    );

    always_comb begin
        case (sel)
            SEL_LEVEL: rd_pins = level;
            SEL_DIR:   rd_pins = dir;
            SEL_RISE:  rd_pins = rise_en;
            SEL_FALL:  rd_pins = fall_en;
            SEL_STAT:  rd_pins = status;
            SEL_ALT:   rd_pins = alt;
            default:   rd_pins = '0;
        endcase
        bus_rdata                 = '0;
        bus_rdata[NUM_PINS-1:0]   = rd_pins;
    end

    assign pin_out = latch;
    assign pin_oe  = dir;

endmodule

// File: rtl/gpio_edge_unit_chk.sv
module gpio_edge_unit_chk #(
    parameter int NUM_PINS = 28,
    parameter int NUM_SOLO = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          bus_word,
    input logic                bus_we,
    input logic [NUM_PINS-1:0] wr_bits,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_SOLO-1:0] irq_solo,
    input logic                irq_upper
);

    logic wr_dir, wr_set, wr_clr, wr_stat;
    assign wr_dir  = bus_we && bus_word == 3'd1;
    assign wr_set  = bus_we && bus_word == 3'd2;
    assign wr_clr  = bus_we && bus_word == 3'd3;
    assign wr_stat = bus_we && bus_word == 3'd6;

    assert_dir_drives_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == $past(wr_bits));

    assert_set_merges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> pin_out == ($past(pin_out) | $past(wr_bits)));

    assert_clr_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> pin_out == ($past(pin_out) & ~$past(wr_bits)));

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pin_out));

    assert_setclr_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word == 3'd2 || bus_word == 3'd3) |-> bus_rdata == 32'd0);

    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (irq_solo & $past(irq_solo)) == $past(irq_solo));

    assert_irq_matches_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_word == 3'd6 |-> (bus_rdata[NUM_SOLO-1:0] == irq_solo &&
                              irq_upper == |bus_rdata[NUM_PINS-1:NUM_SOLO]));

    assert_top_bits_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:NUM_PINS] == '0);

endmodule

bind gpio_edge_unit gpio_edge_unit_chk #(.NUM_PINS(NUM_PINS), .NUM_SOLO(NUM_SOLO)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_word  (bus_word),
    .bus_we    (bus_we),
    .wr_bits   (wdata_pins),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_solo  (irq_solo),
    .irq_upper (irq_upper)
);

// File: tb/gpio_edge_unit_test.sv
module gpio_edge_unit_test;

    localparam int NP = 28;
    localparam int NS = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bus_word = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic [NS-1:0] irq_solo;
    logic          irq_upper;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    gpio_edge_unit #(.NUM_PINS(NP), .NUM_SOLO(NS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_solo(irq_solo), .irq_upper(irq_upper)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        bus_word = w; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        bus_word = w; #1; d = bus_rdata;
    endtask

    task automatic settle;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int w = 1; w < 8; w++) begin
            rd(3'(w), v); check("R1 reset word", v, 32'd0);
        end
        check("R1 pin_oe", 32'(pin_oe), 32'd0);
        check("R1 pin_out", 32'(pin_out), 32'd0);
        check("R1 irq", {20'd0, irq_upper, irq_solo}, 32'd0);
    endtask

    task automatic t_dir;
        logic [31:0] v;
        wr(3'd1, 32'h0F0000FF);
        rd(3'd1, v); check("R3 dir readback", v, 32'h0F0000FF);
        check("R3 pin_oe", 32'(pin_oe), 32'h0F0000FF);
        wr(3'd1, 32'hFFFFFFFF);
        rd(3'd1, v); check("R12 dir top bits", v, 32'h0FFFFFFF);
    endtask

    task automatic t_latch;
        logic [31:0] v;
        wr(3'd2, 32'h00000505);
        wr(3'd2, 32'h00A00000);
        check("R4 set merge", 32'(pin_out), 32'h00A00505);
        wr(3'd3, 32'h00000401);
        check("R5 clear", 32'(pin_out), 32'h00A00104);
        wr(3'd3, 32'h0);
        check("R5 zero clear", 32'(pin_out), 32'h00A00104);
        rd(3'd2, v); check("R6 set reads 0", v, 32'd0);
        rd(3'd3, v); check("R6 clear reads 0", v, 32'd0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        pin_in = 28'hABCDEF1;
        @(posedge clk); @(negedge clk);
        rd(3'd0, v); check("R2 level not yet", v, 32'd0);
        @(posedge clk); @(negedge clk);
        rd(3'd0, v); check("R2 level after 2", v, 32'h0ABCDEF1);
        settle();
        rd(3'd6, v); check("R8 no enable no status", v, 32'd0);
        pin_in = '0; settle();
        wr(3'd1, 32'h0);
        rd(3'd0, v); check("R2 level zero", v, 32'd0);
    endtask

    task automatic t_edges;
        logic [31:0] v;
        wr(3'd4, (32'd1 << 3) | (32'd1 << 21));
        wr(3'd5, (32'd1 << 4) | (32'd1 << 21));
        pin_in = NP'((32'd1 << 3) | (32'd1 << 4) | (32'd1 << 21));
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd6, v); check("R7 not before third edge", v, 32'd0);
        @(posedge clk); @(negedge clk);
        rd(3'd6, v); check("R7 rise status", v, 32'h00200008);
        check("R11 solo", 32'(irq_solo), 32'h8);
        check("R11 upper", 32'(irq_upper), 32'd1);
        wr(3'd6, 32'hFFFFFFFF);
        rd(3'd6, v); check("R9 clear all", v, 32'd0);
        check("R11 upper clear", 32'(irq_upper), 32'd0);
        pin_in = '0; settle();
        rd(3'd6, v); check("R8 fall and both", v, 32'h00200010);
        wr(3'd6, 32'h0);
        rd(3'd6, v); check("R9 zero write", v, 32'h00200010);
        wr(3'd6, 32'h10);
        rd(3'd6, v); check("R9 w1c one bit", v, 32'h00200000);
        check("R11 solo4 off", 32'(irq_solo), 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        pin_in = NP'(32'd1 << 21);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(3'd6, 32'd1 << 21);
        rd(3'd6, v); check("R10 edge wins", v, 32'h00200000);
        wr(3'd6, 32'd1 << 21);
        rd(3'd6, v); check("R10 later clear", v, 32'd0);
    endtask

    task automatic t_alt;
        logic [31:0] v;
        wr(3'd7, 32'hFFFF1234);
        rd(3'd7, v); check("R12 alt storage", v, 32'h0FFF1234);
        check("R12 alt no pin effect", 32'(pin_out), 32'h00A00104);
    endtask

    initial begin
        #(20 * 100000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_latch();
        t_level();
        t_edges();
        t_collide();
        t_alt();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule